// File: doc/BRIEF.md
# Bit-Banged Serial Command Slave

This block sits behind a host-side port register through which software drives a two-wire serial link by hand. Each line has a level bit and a drive-enable bit in that register. The block watches every write to the register and recognises a clock pulse as a rising clock level, qualified by the clock drive-enable that was already in place before the write. While the host drives the data line, each pulse shifts one bit into an 8-bit command register, most significant bit first.

A complete command byte does one of three things. It loads a 4-bit address pointer, or it writes a 4-bit nibble to the addressed entry of a 16-entry register file that sits outside the block, or it fetches a byte from that register file. A fetched byte goes back to the host one bit at a time. Its top bit is visible at once in the data position of the port readback. Each later pulse, with the host's data drive released, steps to the next lower bit. Malformed commands are dropped and raise a sticky flag.

Top module: `bbs_slave`

## Requirements
- R1: Port bit layout: bit 0 is the clock level, bit 1 the clock drive-enable, bit 2 the data level and bit 3 the data drive-enable. A clock pulse is a port write whose bit 0 is 1 while the stored bit 0 is 0 and the stored bit 1 is already 1. No other write moves any serial state.
- R2: On a clock pulse with bit 3 of the written value set, the written bit 2 shifts into the command byte MSB first. The eighth such bit executes the byte in the same write cycle, and the bit counter returns to 0.
- R3: Command layout: bit 7 must be 1, bit 6 is 1 for read and 0 for write, bits 5:4 are 10 for address transfer and 01 for data transfer, and bits 3:0 are the nibble. An address-transfer command loads the nibble into the address pointer. A read with address transfer fetches from the newly loaded address.
- R4: A legal write data-transfer command asserts `rf_we_o` for that one cycle, with `rf_addr_o` set to the current pointer and `rf_wdata_o` set to bits 3:0.
- R5: A legal read command samples `rf_rdata_i` at `rf_addr_o` in the executing cycle. Bit 7 of that byte appears in bit 2 of `port_rdata_o` directly after that write, and the read index is set to 0.
- R6: On a clock pulse with bit 3 of the written value clear, the read index advances modulo 8 and the next lower bit of the fetched byte is presented. After the eighth such pulse, bit 7 is presented again. The host's own data level in these writes has no effect.
- R7: `port_rdata_o` returns the last written port value with bit 2 replaced by the slave output bit, which is 0 after reset.
- R8: A command with bit 7 clear, or with bits 5:4 equal to 00 or 11, changes neither the pointer, the register file nor the output bit, and sets `illegal_o`. `illegal_o` stays set until reset.
- R9: The asynchronous active-low reset clears the shift register, both bit counters, the address pointer, the port register, the output bit and the illegal flag. A partly shifted byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_we_i | input | 1 | Port register write strobe |
| port_wdata_i | input | PORT_W | Port register write value |
| port_rdata_o | output | PORT_W | Port register readback |
| rf_we_o | output | 1 | Register file nibble write enable |
| rf_addr_o | output | 4 | Register file address |
| rf_wdata_o | output | 4 | Register file write nibble |
| rf_rdata_i | input | DATA_W | Register file read byte, combinational from rf_addr_o |
| illegal_o | output | 1 | Sticky illegal-command flag |

## Verification
The assertions assume that every port write lasts one clock cycle. They also assume that the register file returns `rf_rdata_i` combinationally from `rf_addr_o`, so that a fetch and a nibble write settle in the executing cycle. The bench writes to the port only through a one-cycle write task. It models the register file as a combinational read with a clocked nibble write. It drives both lines only through those tasks, so every write is a single well-formed edge. The spurious edges it inserts (drive-enable off, repeated high level) are still single port writes.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = NIB_W;

  // port register bit positions
  localparam int unsigned PIN_CLK_LVL = 0;
  localparam int unsigned PIN_CLK_OE  = 1;
  localparam int unsigned PIN_DAT_LVL = 2;
  localparam int unsigned PIN_DAT_OE  = 3;

  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_DATA = 2'b01,
    XFER_ADDR = 2'b10,
    XFER_BAD  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic             mark;
    logic             rd;
    xfer_e            xfer;
    logic [NIB_W-1:0] nib;
  } cmd_t;
endpackage

// File: rtl/bbs_port_reg.sv
module bbs_port_reg
  import bbs_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              slave_bit_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic              pulse_o,
  output logic              dat_oe_o,
  output logic              dat_lvl_o
);
  logic [PORT_W-1:0] port_q;

  // edge qualified by the drive-enable held before this write
  assign pulse_o   = we_i & port_q[PIN_CLK_OE] & wdata_i[PIN_CLK_LVL] & ~port_q[PIN_CLK_LVL];
  assign dat_oe_o  = wdata_i[PIN_DAT_OE];
  assign dat_lvl_o = wdata_i[PIN_DAT_LVL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   port_q <= '0;
    else if (we_i) port_q <= wdata_i;
  end

  always_comb begin
    rdata_o              = port_q;
    rdata_o[PIN_DAT_LVL] = slave_bit_i;
  end
endmodule

// File: rtl/bbs_cmd_core.sv
module bbs_cmd_core
  import bbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              shift_mode_i,
  input  logic              bit_i,
  output logic              fetch_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [NIB_W-1:0]  rf_wdata_o,
  output logic              illegal_o
);
  localparam int unsigned CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0]  shift_q, byte_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              illegal_q;
  logic              take, done, legal, is_addr, is_data;
  cmd_t              cmd;

  assign take    = pulse_i & shift_mode_i;
  assign byte_n  = {shift_q[CMD_W-2:0], bit_i};
  assign done    = take && (cnt_q == CNT_W'(CMD_W - 1));
  assign cmd     = cmd_t'(byte_n);
  assign is_addr = (cmd.xfer == XFER_ADDR);
  assign is_data = (cmd.xfer == XFER_DATA);
  assign legal   = cmd.mark & (is_addr | is_data);

  // address load takes effect for a fetch in the same command
  assign rf_addr_o  = (done && legal && is_addr) ? cmd.nib : addr_q;
  assign rf_wdata_o = cmd.nib;
  assign rf_we_o    = done & legal & ~cmd.rd & is_data;
  assign fetch_o    = done & legal & cmd.rd;
  assign illegal_o  = illegal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      addr_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (take) begin
        shift_q <= byte_n;
        cnt_q   <= done ? '0 : cnt_q + 1'b1;
      end
      if (done && legal && is_addr) addr_q <= cmd.nib;
      if (done && !legal)           illegal_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bbs_read_out.sv
module bbs_read_out #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              bit_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              bit_q;

  assign idx_n = idx_q + 1'b1;
  assign bit_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      idx_q  <= '0;
      bit_q  <= 1'b0;
    end else if (load_i) begin
      byte_q <= data_i;
      idx_q  <= '0;
      bit_q  <= data_i[DATA_W-1];
    end else if (step_i) begin
      idx_q <= idx_n;
      bit_q <= byte_q[IDX_W'(DATA_W - 1) - idx_n];
    end
  end
endmodule

// File: rtl/bbs_slave.sv
module bbs_slave
  import bbs_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_we_i,
  input  logic [PORT_W-1:0] port_wdata_i,
  output logic [PORT_W-1:0] port_rdata_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [NIB_W-1:0]  rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              illegal_o
);
  logic pulse, dat_oe, dat_lvl, fetch, slave_bit;

  bbs_port_reg #(.PORT_W(PORT_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (port_we_i),
    .wdata_i     (port_wdata_i),
    .slave_bit_i (slave_bit),
    .rdata_o     (port_rdata_o),
    .pulse_o     (pulse),
    .dat_oe_o    (dat_oe),
    .dat_lvl_o   (dat_lvl)
  );

  bbs_cmd_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pulse_i      (pulse),
    .shift_mode_i (dat_oe),
    .bit_i        (dat_lvl),
    .fetch_o      (fetch),
    .rf_we_o      (rf_we_o),
    .rf_addr_o    (rf_addr_o),
    .rf_wdata_o   (rf_wdata_o),
    .illegal_o    (illegal_o)
  );

  bbs_read_out #(.DATA_W(DATA_W)) u_rdout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fetch),
    .data_i (rf_rdata_i),
    .step_i (pulse & ~dat_oe),
    .bit_o  (slave_bit)
  );
endmodule

// File: rtl/bbs_slave_chk.sv
module bbs_slave_chk
  import bbs_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_we_i,
  input logic [PORT_W-1:0] port_wdata_i,
  input logic [PORT_W-1:0] port_rdata_o,
  input logic              rf_we_o,
  input logic              illegal_o
);
  localparam logic [PORT_W-1:0] KEEP = ~(PORT_W'(1) << PIN_DAT_LVL);

  p_exec_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> port_wdata_i[PIN_CLK_LVL] && port_rdata_o[PIN_CLK_OE] && !port_rdata_o[PIN_CLK_LVL]);

  p_we_needs_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> port_we_i);

  p_readback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_i |=> (port_rdata_o & KEEP) == ($past(port_wdata_i) & KEEP));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we_i |=> $stable(port_rdata_o));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  p_legal_no_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> $stable(illegal_o));
endmodule

bind bbs_slave bbs_slave_chk #(.PORT_W(PORT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_we_i    (port_we_i),
  .port_wdata_i (port_wdata_i),
  .port_rdata_o (port_rdata_o),
  .rf_we_o      (rf_we_o),
  .illegal_o    (illegal_o)
);

// File: tb/bbs_slave_bench.sv
module bbs_slave_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       port_we = 1'b0;
  logic [7:0] port_wdata = '0;
  logic [7:0] port_rdata;
  logic       rf_we, illegal;
  logic [3:0] rf_addr, rf_wdata;
  logic [7:0] rf_rdata;

  logic [7:0] mem [16];
  logic       pl_en = 1'b0;
  logic [3:0] pl_addr = '0;
  logic [7:0] pl_val = '0;

  logic [7:0] exp_mem [16];
  logic [3:0] exp_addr;
  logic       exp_ill;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bbs_slave u_bbs_slave (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .port_we_i    (port_we),
    .port_wdata_i (port_wdata),
    .port_rdata_o (port_rdata),
    .rf_we_o      (rf_we),
    .rf_addr_o    (rf_addr),
    .rf_wdata_o   (rf_wdata),
    .rf_rdata_i   (rf_rdata),
    .illegal_o    (illegal)
  );

  // register file model: combinational read, clocked nibble write
  assign rf_rdata = mem[rf_addr];
  always_ff @(posedge clk_i) begin
    if (pl_en)      mem[pl_addr] <= pl_val;
    else if (rf_we) mem[rf_addr] <= {mem[rf_addr][7:4], rf_wdata};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] pv(input bit c_oe, input bit c, input bit d_oe, input bit d);
    return {4'b0, d_oe, d, c_oe, c};
  endfunction

  task automatic port_wr(input logic [7:0] v);
    @(negedge clk_i);
    port_we = 1'b1;
    port_wdata = v;
    @(negedge clk_i);
    port_we = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    port_wr(pv(1, 0, 1, b));
    port_wr(pv(1, 1, 1, b));
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic read_bit(output bit b);
    port_wr(pv(1, 0, 0, 1'($urandom % 2)));
    port_wr(pv(1, 1, 0, 1'($urandom % 2)));
    b = port_rdata[2];
  endtask

  task automatic read_byte(output logic [7:0] v);
    bit b;
    v[7] = port_rdata[2];
    for (int i = 6; i >= 0; i--) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic model_reset();
    exp_addr = '0;
    exp_ill  = 1'b0;
  endtask

  // apply command to model; for reads, shift the byte out and compare
  task automatic do_cmd(input logic [7:0] c, input string tag);
    logic [7:0] got;
    bit legal;
    send_byte(c);
    legal = c[7] && (c[5:4] == 2'b01 || c[5:4] == 2'b10);
    if (!legal) exp_ill = 1'b1;
    else begin
      if (c[5:4] == 2'b10) exp_addr = c[3:0];
      if (!c[6] && c[5:4] == 2'b01) exp_mem[exp_addr][3:0] = c[3:0];
      if (c[6]) begin
        read_byte(got);
        check(got == exp_mem[exp_addr], tag, got, exp_mem[exp_addr]);
      end
    end
    check(illegal == exp_ill, {tag, " flag R8"}, illegal, exp_ill);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      report();
    end
  end

  initial begin
    logic [7:0] got, op;
    bit b, keep;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      pl_en = 1'b1; pl_addr = 4'(i); pl_val = 8'($urandom);
      exp_mem[i] = pl_val;
    end
    @(negedge clk_i); pl_en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk_i);
    check(port_rdata == 8'h00, "R9 reset port", port_rdata, 0);
    check(illegal == 1'b0, "R9 reset flag", illegal, 0);
    rst_ni = 1'b1;

    // R7 readback: data bit replaced by slave bit (0)
    port_wr(8'hFB);
    check(port_rdata == 8'hFB, "R7 readback a", port_rdata, 8'hFB);
    port_wr(8'hF6);
    check(port_rdata == 8'hF2, "R7 readback b", port_rdata, 8'hF2);
    port_wr(pv(1, 0, 1, 0));

    // R3/R5/R6: address load, read, wrap
    do_cmd(8'hA5, "R3 addr load");
    do_cmd(8'hD0, "R5 read");
    read_bit(b);
    check(b == exp_mem[5][7], "R6 wrap to msb", b, exp_mem[5][7]);

    // R4 nibble write then read back
    do_cmd(8'h9C, "R4 write");
    do_cmd(8'hD0, "R4 readback");

    // R3 read with address transfer
    do_cmd(8'hEA, "R3 read+addr");
    check(rf_addr == 4'hA, "R3 pointer", rf_addr, 4'hA);

    // R1 spurious edges: drive-enable cleared, repeated high level
    for (int i = 7; i >= 4; i--) send_bit(1'(8'hA3 >> i));
    port_wr(pv(0, 0, 1, 1));
    port_wr(pv(0, 1, 1, 1));
    port_wr(pv(1, 1, 1, 1));
    port_wr(pv(1, 0, 1, 0));
    for (int i = 3; i >= 0; i--) begin
      send_bit(1'(8'hA3 >> i));
      port_wr(pv(1, 1, 1, 1'(8'hA3 >> i)));
    end
    exp_addr = 4'h3;
    check(rf_addr == 4'h3, "R1 edge qualify", rf_addr, 4'h3);
    do_cmd(8'hD0, "R1 R2 read after spurious");

    // R8 illegal commands ignored
    keep = port_rdata[2];
    do_cmd(8'h35, "R8 bit7 clear");
    do_cmd(8'h85, "R8 xfer 00");
    do_cmd(8'hB7, "R8 xfer 11");
    do_cmd(8'hF1, "R8 read xfer 11");
    check(port_rdata[2] == keep, "R8 out bit kept", port_rdata[2], keep);
    check(rf_addr == exp_addr, "R8 pointer kept", rf_addr, exp_addr);
    do_cmd(8'hD0, "R8 mem kept");

    // R9 reset mid-byte
    for (int i = 7; i >= 5; i--) send_bit(1'(8'hAF >> i));
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    model_reset();
    check(illegal == 1'b0 && port_rdata == 8'h00, "R9 reset mid", {illegal, port_rdata}, 0);
    rst_ni = 1'b1;
    port_wr(pv(1, 0, 1, 0));
    do_cmd(8'hD0, "R9 pointer zero read");

    // random legal traffic
    for (int n = 0; n < 80; n++) begin
      case ($urandom % 4)
        0: op = 8'hA0 | 8'($urandom % 16);
        1: op = 8'h90 | 8'($urandom % 16);
        2: op = 8'hD0;
        default: op = 8'hE0 | 8'($urandom % 16);
      endcase
      do_cmd(op, "R2 R3 R4 R5 R6 random");
    end

    done = 1;
    report();
  end
endmodule